// File: doc/BRIEF.md
# Mailbox Identifier Write Guard with Denied-Write Interrupt

This block holds the register-side state of a bank of message mailboxes for a CAN controller. Each mailbox stores a 32-bit identifier and two 32-bit data words. A per-mailbox enable register marks which mailboxes are active. While a mailbox is enabled, its identifier is locked. A host write that targets that identifier is dropped, and a sticky write-denied flag is set in its place.

The flag can be reported on either of two interrupt lines, chosen by a line-select control bit. A line asserts only when three things hold together: the flag is set, the global denied-write mask bit is set, and that line's own enable bit is set. Software clears the flag by writing 1 to bit 0 of the flag register that belongs to the selected line. A second denied write that arrives while the flag is still set produces no new event, because the flag is already high.

The host side is a plain register bus. It has a single-cycle write strobe with word address, byte lanes and data, and a combinational read port. No data streams through the block, so neither side needs valid/ready handshaking, and there is no back-pressure: every write completes in the cycle its strobe is sampled.

Top module: `mbxwp_top`

## Requirements
- R1: A write with any byte lane set to word 0 (identifier) of mailbox n, while enable bit n is 1, leaves that identifier unchanged and sets the write-denied flag at the same clock edge.
- R2: When enable bit n is 0, writes to the identifier of mailbox n are stored. Writes to the two data words of mailbox n are stored whether or not the mailbox is enabled.
- R3: Line select is control bit 1. When it is 0, the flag reads as bit 0 of flag register 0 and flag register 1 reads 0. When it is 1, the flag reads as bit 0 of flag register 1 and flag register 0 reads 0. The two interrupt lines are never high together.
- R4: irq0_o is high exactly when the flag, mask (control bit 0) and line-0 enable (control bit 2) are all 1 and line select is 0. irq1_o is high exactly when the flag, mask and line-1 enable (control bit 3) are all 1 and line select is 1.
- R5: A full-width write with data bit 0 equal to 1, made to the flag register of the selected line, clears the flag, and the asserted interrupt line is low in the next cycle. A write of 0, or a write to the unselected flag register, leaves the flag set.
- R6: A denied write made while the flag is already set keeps the flag set, and keeps the active line high in every cycle with no low gap.
- R7: Reset clears all identifiers, data words, the enable register, the control register and the flag, and both interrupt lines are low.
- R8: Writes to the enable, control and flag registers take effect only when all four byte lanes are set; any other lane pattern is ignored. Mailbox words are updated per byte lane.
- R9: Word address map: 0x000 is the enable register (bit n = mailbox n), 0x001 the control register, 0x002 flag register 0 and 0x003 flag register 1. Mailbox n occupies 0x100+4n: word 0 holds the identifier, word 1 low data and word 2 high data. Word 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_waddr | input | 9 | Write word address |
| bus_be | input | 4 | Write byte lanes |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 9 | Read word address |
| bus_rdata | output | 32 | Read data, combinational from bus_raddr |
| irq0_o | output | 1 | Denied-write interrupt, line 0 (level) |
| irq1_o | output | 1 | Denied-write interrupt, line 1 (level) |

## Verification
The assertions assume that the host issues at most one write per clock. Because of that, a flag clear and a denied write can never reach the flag logic in the same cycle. They also assume that the bus inputs are at known values whenever the write strobe is high. The bench drives every write through one task, which raises the strobe for exactly one cycle and holds all other bus fields stable during it. Between writes the strobe stays low, so the stickiness and clear properties are only ever exercised one event at a time.

// File: rtl/mbxwp_pkg.sv
package mbxwp_pkg;
  localparam int unsigned AW = 9;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] A_ENABLE = 9'h000;
  localparam logic [AW-1:0] A_CTRL   = 9'h001;
  localparam logic [AW-1:0] A_FLAG0  = 9'h002;
  localparam logic [AW-1:0] A_FLAG1  = 9'h003;
  localparam logic [AW-1:0] A_MBX    = 9'h100;

  typedef enum logic [1:0] {
    W_IDENT = 2'd0,
    W_DLOW  = 2'd1,
    W_DHIGH = 2'd2,
    W_RSVD  = 2'd3
  } mbx_word_e;

  typedef struct packed {
    logic line1_en;
    logic line0_en;
    logic line_sel;
    logic wd_mask;
  } ctl_t;
endpackage

// File: rtl/mbxwp_store.sv
module mbxwp_store
  import mbxwp_pkg::*;
#(
  parameter int unsigned NUM_MBX = 32,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_MBX),
  localparam int unsigned NB     = DATA_W / 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [IDX_W-1:0]                  widx,
  input  logic [1:0]                        wword,
  input  logic [NB-1:0]                     be,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [IDX_W-1:0]                  ridx,
  input  logic [1:0]                        rword,
  output logic [DATA_W-1:0]                 rdata,
  output logic [NUM_MBX-1:0][DATA_W-1:0]    id_flat
);
  logic [NUM_MBX-1:0][DATA_W-1:0] id_q, dlo_q, dhi_q;
  logic [DATA_W-1:0] bmask;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign bmask[g*8 +: 8] = {8{be[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
    end else if (we) begin
      for (int m = 0; m < NUM_MBX; m++) begin
        if (widx == IDX_W'(m)) begin
          case (mbx_word_e'(wword))
            W_IDENT: id_q[m]  <= (id_q[m]  & ~bmask) | (wdata & bmask);
            W_DLOW:  dlo_q[m] <= (dlo_q[m] & ~bmask) | (wdata & bmask);
            W_DHIGH: dhi_q[m] <= (dhi_q[m] & ~bmask) | (wdata & bmask);
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (mbx_word_e'(rword))
      W_IDENT: rdata = id_q[ridx];
      W_DLOW:  rdata = dlo_q[ridx];
      W_DHIGH: rdata = dhi_q[ridx];
      default: rdata = '0;
    endcase
  end

  assign id_flat = id_q;
endmodule

// File: rtl/mbxwp_ctrl.sv
module mbxwp_ctrl
  import mbxwp_pkg::*;
#(
  parameter int unsigned NUM_MBX = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_enable,
  input  logic               we_ctl,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_MBX-1:0] enable_q,
  output ctl_t               ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      ctl_q    <= '0;
    end else begin
      if (we_enable) enable_q <= wdata[NUM_MBX-1:0];
      if (we_ctl)    ctl_q    <= ctl_t'(wdata[$bits(ctl_t)-1:0]);
    end
  end
endmodule

// File: rtl/mbxwp_flag.sv
module mbxwp_flag
  import mbxwp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic deny,
  input  logic clr,
  input  ctl_t ctl,
  output logic flag_q,
  output logic irq0,
  output logic irq1
);
  // a denial wins over a clear if both ever arrive together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (deny) flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;
  end

  logic armed;
  assign armed = flag_q & ctl.wd_mask;
  assign irq0  = armed & ~ctl.line_sel & ctl.line0_en;
  assign irq1  = armed &  ctl.line_sel & ctl.line1_en;
endmodule

// File: rtl/mbxwp_top.sv
module mbxwp_top
  import mbxwp_pkg::*;
#(
  parameter int unsigned NUM_MBX = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_MBX),
  localparam int unsigned NB     = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [NB-1:0] bus_be,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_rdata,
  output logic          irq0_o,
  output logic          irq1_o
);
  localparam int unsigned SPAN_SH = IDX_W + 2;

  logic [AW-1:0] woff, roff;
  logic          w_mbx, r_mbx, full;
  logic [IDX_W-1:0] widx;
  logic [1:0]    wword;

  assign woff  = bus_waddr - A_MBX;
  assign roff  = bus_raddr - A_MBX;
  assign w_mbx = bus_waddr[AW-1] && ((woff >> SPAN_SH) == '0);
  assign r_mbx = bus_raddr[AW-1] && ((roff >> SPAN_SH) == '0);
  assign widx  = woff[SPAN_SH-1:2];
  assign wword = woff[1:0];
  assign full  = &bus_be;

  logic [NUM_MBX-1:0] enable_q;
  ctl_t               ctl_q;
  logic               flag_q;
  logic               denied, clr_req, st_we;
  logic [DW-1:0]      st_rdata;
  logic [NUM_MBX-1:0][DW-1:0] id_flat;

  assign denied  = bus_we && w_mbx && (wword == W_IDENT) && enable_q[widx] && (|bus_be);
  assign st_we   = bus_we && w_mbx && !denied;
  assign clr_req = bus_we && full && bus_wdata[0] &&
                   ((bus_waddr == A_FLAG0 && !ctl_q.line_sel) ||
                    (bus_waddr == A_FLAG1 &&  ctl_q.line_sel));

  mbxwp_store #(.NUM_MBX(NUM_MBX), .DATA_W(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .widx(widx), .wword(wword),
    .be(bus_be), .wdata(bus_wdata), .ridx(roff[SPAN_SH-1:2]),
    .rword(roff[1:0]), .rdata(st_rdata), .id_flat(id_flat)
  );

  mbxwp_ctrl #(.NUM_MBX(NUM_MBX), .DATA_W(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .we_enable(bus_we && full && bus_waddr == A_ENABLE),
    .we_ctl(bus_we && full && bus_waddr == A_CTRL),
    .wdata(bus_wdata), .enable_q(enable_q), .ctl_q(ctl_q)
  );

  mbxwp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .deny(denied), .clr(clr_req), .ctl(ctl_q),
    .flag_q(flag_q), .irq0(irq0_o), .irq1(irq1_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (r_mbx) bus_rdata = st_rdata;
    else begin
      case (bus_raddr)
        A_ENABLE: bus_rdata = DW'(enable_q);
        A_CTRL:   bus_rdata = DW'(ctl_q);
        A_FLAG0:  bus_rdata = DW'(flag_q & ~ctl_q.line_sel);
        A_FLAG1:  bus_rdata = DW'(flag_q &  ctl_q.line_sel);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbxwp_chk.sv
module mbxwp_chk
  import mbxwp_pkg::*;
#(
  parameter int unsigned NUM_MBX = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_we,
  input logic [AW-1:0]                bus_waddr,
  input logic [DW/8-1:0]              bus_be,
  input logic                         denied,
  input logic                         clr_req,
  input logic                         flag_q,
  input ctl_t                         ctl_q,
  input logic [NUM_MBX-1:0]           enable_q,
  input logic [NUM_MBX-1:0][DW-1:0]   id_flat,
  input logic                         irq0_o,
  input logic                         irq1_o
);
  logic partial_reg_we;
  assign partial_reg_we = bus_we && !(&bus_be) &&
                          (bus_waddr == A_ENABLE || bus_waddr == A_CTRL);

  assert_deny_keeps_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
    denied |=> $stable(id_flat));

  assert_deny_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    denied |=> flag_q);

  assert_one_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq0_o && irq1_o));

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !denied) |=> (!flag_q && !irq0_o && !irq1_o));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);

  assert_irq0_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0_o && !clr_req && !(bus_we && bus_waddr == A_CTRL)) |=> irq0_o);

  assert_partial_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    partial_reg_we |=> ($stable(ctl_q) && $stable(enable_q)));
endmodule

bind mbxwp_top mbxwp_chk #(.NUM_MBX(NUM_MBX)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
  .bus_be(bus_be), .denied(denied), .clr_req(clr_req), .flag_q(flag_q),
  .ctl_q(ctl_q), .enable_q(enable_q), .id_flat(id_flat),
  .irq0_o(irq0_o), .irq1_o(irq1_o)
);

// File: tb/mbxwp_top_tb.sv
module mbxwp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [8:0]  bus_waddr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [8:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic        irq0_o, irq1_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mbxwp_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata), .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {30'b0, irq1_o, irq0_o} : bus_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d,
                    input logic [3:0] be = 4'hF);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic exp_rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_raddr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic exp_irq(input logic [1:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {30'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #2;
  endtask

  function automatic logic [8:0] mb(input int n, input int w);
    return 9'h100 + 9'(4 * n + w);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;

    // R7 reset state
    exp_rd(9'h000, 32'h0, "R7 enable reset");
    exp_rd(9'h001, 32'h0, "R7 ctrl reset");
    exp_rd(9'h002, 32'h0, "R7 flag0 reset");
    exp_rd(mb(13, 0), 32'h0, "R7 ident reset");
    exp_irq(2'b00, "R7 irq reset");

    // R2 / R9 disabled mailbox accepts writes
    wr(mb(13, 0), 32'h9555AA13);
    wr(mb(13, 1), 32'h31313131);
    wr(mb(13, 2), 32'h13131313);
    wr(mb(13, 3), 32'hDEADBEEF);
    exp_rd(mb(13, 0), 32'h9555AA13, "R2 ident stored while disabled");
    exp_rd(mb(13, 1), 32'h31313131, "R9 data low word");
    exp_rd(mb(13, 2), 32'h13131313, "R9 data high word");
    exp_rd(mb(13, 3), 32'h0, "R9 word 3 reads zero");

    // enable mailbox 13, line 0 armed
    wr(9'h000, 32'h1 << 13);
    exp_rd(9'h000, 32'h0000_2000, "R9 enable bit 13");
    wr(9'h001, 32'h5);
    wr(9'h001, 32'hF, 4'h3);
    exp_rd(9'h001, 32'h5, "R8 partial ctrl write ignored");
    wr(9'h000, 32'hFFFF_FFFF, 4'h7);
    exp_rd(9'h000, 32'h0000_2000, "R8 partial enable write ignored");
    exp_irq(2'b00, "R4 no irq before denial");

    // R1 denied write
    wr(mb(13, 0), 32'h9555AA00);
    exp_rd(mb(13, 0), 32'h9555AA13, "R1 ident kept");
    exp_rd(9'h002, 32'h1, "R3 flag in reg0 with sel 0");
    exp_rd(9'h003, 32'h0, "R3 reg1 clear with sel 0");
    exp_irq(2'b01, "R4 line0 asserted");

    // R2 data write on enabled mailbox accepted
    wr(mb(13, 1), 32'hCAFE0001);
    exp_rd(mb(13, 1), 32'hCAFE0001, "R2 data stored while enabled");

    // R6 second denial while flag set: line stays high each cycle
    exp_irq(2'b01, "R6 before second denial");
    bus_we = 1'b1; bus_waddr = mb(13, 0); bus_wdata = 32'h9555AA00; bus_be = 4'hF;
    exp_irq(2'b01, "R6 during second denial");
    bus_we = 1'b0; bus_be = '0;
    exp_irq(2'b01, "R6 after second denial");
    exp_rd(mb(13, 0), 32'h9555AA13, "R1 ident kept on second denial");

    // R5 / R8 non-clearing writes
    wr(9'h002, 32'h0);
    exp_irq(2'b01, "R5 write of zero keeps flag");
    wr(9'h003, 32'h1);
    exp_irq(2'b01, "R5 unselected reg keeps flag");
    wr(9'h002, 32'h1, 4'h1);
    exp_irq(2'b01, "R8 partial clear ignored");

    // R5 proper clear: line low next cycle
    wr(9'h002, 32'h1);
    exp_irq(2'b00, "R5 irq low after clear");
    exp_rd(9'h002, 32'h0, "R5 flag0 cleared");

    // R4 mask off: flag set, no irq
    wr(9'h001, 32'h4);
    wr(mb(13, 0), 32'h1);
    exp_irq(2'b00, "R4 masked flag");
    exp_rd(9'h002, 32'h1, "R4 flag set while masked");

    // R3 reroute to line 1
    wr(9'h001, 32'hB);
    exp_rd(9'h003, 32'h1, "R3 flag in reg1 with sel 1");
    exp_rd(9'h002, 32'h0, "R3 reg0 clear with sel 1");
    exp_irq(2'b10, "R3 line1 asserted");
    wr(9'h001, 32'h3);
    exp_irq(2'b00, "R4 line1 enable off");
    wr(9'h001, 32'hB);
    wr(9'h002, 32'h1);
    exp_irq(2'b10, "R5 clear on unselected reg0 ignored");
    wr(9'h003, 32'h1);
    exp_irq(2'b00, "R5 clear via reg1");

    // boundary mailboxes 0 and 31
    wr(mb(31, 0), 32'h31313100);
    wr(mb(0, 0), 32'h00000077);
    wr(9'h000, 32'hFFFF_FFFF);
    wr(mb(31, 0), 32'h0BAD0BAD);
    wr(mb(0, 0), 32'h0BAD0BAD);
    exp_rd(mb(31, 0), 32'h31313100, "R1 ident 31 kept");
    exp_rd(mb(0, 0), 32'h00000077, "R1 ident 0 kept");
    exp_irq(2'b10, "R1 denial on mailbox 31 flags line1");

    // R8 byte lanes on mailbox data
    wr(mb(31, 2), 32'h11223344);
    wr(mb(31, 2), 32'hAABBCCDD, 4'h1);
    exp_rd(mb(31, 2), 32'h112233DD, "R8 byte lane 0 only");

    // R2 disable then identifier writable again
    wr(9'h000, 32'h0);
    wr(mb(13, 0), 32'h12345678);
    exp_rd(mb(13, 0), 32'h12345678, "R2 ident stored after disable");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule